// File: doc/BRIEF.md
# Event Performance Monitor

This block is a per-core performance monitor. It has one dedicated 32-bit cycle counter and a parameterised set of 32-bit event counters. Each event counter is steered by an 8-bit selector to one of 256 single-bit event lines from the core. It advances on every clock in which that line is high, provided the global run bit and the counter's own enable bit are both set.

Software reaches the block through a flat register port with a 4-bit word address. Writes are applied on the clock edge and reads are combinational. Enables and interrupt enables each have a set register and a clear register, so any one counter can be switched without a read-modify-write. Counter wraps are kept as sticky flags that software clears by writing ones. One interrupt line collects every flag whose interrupt enable is set. Event counters are read and written through two windows that act on whichever counter the select register points at. The cycle counter can be slowed to one step per 64 clocks, and it can be set to pause while an external prohibit input is high.

Register map (word address): 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow flags, 6 counter select, 7 cycle counter, 8 selected counter value, 9 selected counter event selector. Addresses 10 to 15 read as zero.

Top module: `perf_mon`

## Requirements
- R1: After reset every counter, enable mask, interrupt-enable mask, overflow flag, event selector and the select register read zero, irq_o is low, and the control register reads only the counter-count field.
- R2: The control register holds run (bit 0), divide-by-64 (bit 3), a spare stored bit (bit 4) and prohibit-pause (bit 5), all readable. Bits 1 and 2 are write-only actions that read 0. Bits 15:11 read the implemented event-counter count (0x2000 for four counters), and no other bit is writable.
- R3: In the enable, interrupt-enable and flag masks, bit n belongs to event counter n and bit 31 to the cycle counter. A 1 written to a set register turns the bit on and a 1 written to the clear register turns it off, while 0 bits leave the mask unchanged. Both addresses of a pair read the current mask. Bits for counters that are not implemented always read 0.
- R4: A counter advances only while control bit 0 and its own enable bit are both 1. An event counter adds one for each clock in which the event line named by its selector is high.
- R5: An enabled cycle counter adds one every clock. With control bit 3 set, it adds one per 64 clocks instead.
- R6: With control bit 5 set, the cycle counter holds while prohibit_i is high. With bit 5 clear, prohibit_i has no effect.
- R7: Writing control bit 1 as 1 zeroes all event counters and leaves the cycle counter unchanged. Writing bit 2 as 1 zeroes the cycle counter and its divider.
- R8: A counter stepping from 0xFFFFFFFF to 0 sets its flag on that same edge. A flag stays set until a 1 is written to its bit at address 5. If a wrap and such a clear land on the same edge, the flag ends up set.
- R9: irq_o is high exactly while some flag and its interrupt enable are both set.
- R10: The select register keeps 5 bits. While it holds a value at or above the event-counter count, both windows read 0 and writes to them change nothing.
- R11: The cycle counter is written directly at address 7. The selected event counter's value (address 8) and its 8-bit selector (address 9) are written and read through the windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 256 | Event lines from the core, one bit per event code |
| prohibit_i | input | 1 | Pauses the cycle counter when control bit 5 is set |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
A counter wrapping and a write-one-to-clear of its own flag can fall on the same clock edge. The bench preloads event counter 0 with 0xFFFFFFFF. It then raises that counter's event line in the very cycle in which it writes 1 to flag bit 0, and afterwards expects the flag still set and the counter at zero. A second collision, where a counter write and a counter increment arrive together, is resolved in favour of the write. Assertions in the counter module check this on every cycle, since only increment-free cycles may show a stable value.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned CYC_BIT = 31;
  localparam int unsigned ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_IE_CLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_CYC    = 4'd7,
    A_EVCNT  = 4'd8,
    A_EVSEL  = 4'd9
  } reg_addr_e;

  // implemented bits of the enable / flag masks
  function automatic logic [CNT_W-1:0] impl_mask(int unsigned n_evt);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < CNT_W - 1; i++) if (i < n_evt) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/perf_mon_counter.sv
module perf_mon_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // clear beats write, write beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~clr_i & ~wr_i & (&cnt_q);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !wr_i) |=> $stable(cnt_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !wr_i) |=> (cnt_q == $past(cnt_q) + W'(1)));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/perf_mon_prescale.sv
module perf_mon_prescale #(
  parameter int unsigned LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic div_i,
  output logic tick_o
);
  logic [LOG2-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + LOG2'(1);
  end

  assign tick_o = run_i & (~div_i | (&pre_q));

  p_div_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && tick_o) |=> !(div_i && tick_o));
  p_full_rate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !div_i) |-> tick_o);
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 4,    // 1..31
  parameter int unsigned NUM_SRC  = 256,  // power of two
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        event_i,
  input  logic                      prohibit_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [CNT_W-1:0]          wdata_i,
  output logic [CNT_W-1:0]          rdata_o,
  output logic                      irq_o
);
  localparam int unsigned EVS_W = $clog2(NUM_SRC);
  localparam int unsigned SEL_W = 5;
  localparam logic [CNT_W-1:0] IMPL = impl_mask(NUM_EVT);

  typedef struct packed {
    logic prh;
    logic spare;
    logic div;
    logic run;
  } ctrl_t;

  ctrl_t                          ctrl_q;
  logic [CNT_W-1:0]               en_q, ie_q, ovf_q, ovf_d;
  logic [SEL_W-1:0]               sel_q;
  logic [NUM_EVT-1:0][EVS_W-1:0]  evsel_q;

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
  logic wr_ovf, wr_sel, wr_cyc, wr_evcnt, wr_evsel;
  logic clr_evt, clr_cyc, sel_ok;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_en_set = wr_en_i && (addr_i == A_EN_SET);
  assign wr_en_clr = wr_en_i && (addr_i == A_EN_CLR);
  assign wr_ie_set = wr_en_i && (addr_i == A_IE_SET);
  assign wr_ie_clr = wr_en_i && (addr_i == A_IE_CLR);
  assign wr_ovf    = wr_en_i && (addr_i == A_OVF);
  assign wr_sel    = wr_en_i && (addr_i == A_SEL);
  assign wr_cyc    = wr_en_i && (addr_i == A_CYC);
  assign wr_evcnt  = wr_en_i && (addr_i == A_EVCNT);
  assign wr_evsel  = wr_en_i && (addr_i == A_EVSEL);

  assign clr_evt = wr_ctrl & wdata_i[1];
  assign clr_cyc = wr_ctrl & wdata_i[2];
  assign sel_ok  = (32'(sel_q) < NUM_EVT);

  // ---------------- configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      ie_q    <= '0;
      sel_q   <= '0;
      evsel_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q <= '{prh: wdata_i[5], spare: wdata_i[4],
                                 div: wdata_i[3], run: wdata_i[0]};
      if (wr_en_set) en_q   <= en_q | (wdata_i & IMPL);
      if (wr_en_clr) en_q   <= en_q & ~wdata_i;
      if (wr_ie_set) ie_q   <= ie_q | (wdata_i & IMPL);
      if (wr_ie_clr) ie_q   <= ie_q & ~wdata_i;
      if (wr_sel)    sel_q  <= wdata_i[SEL_W-1:0];
      for (int i = 0; i < NUM_EVT; i++)
        if (wr_evsel && sel_ok && (sel_q == SEL_W'(i)))
          evsel_q[i] <= wdata_i[EVS_W-1:0];
    end
  end

  // ---------------- event counters
  logic [NUM_EVT-1:0][CNT_W-1:0] ev_cnt;
  logic [NUM_EVT-1:0]            ev_wrap;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic inc;
    assign inc = ctrl_q.run & en_q[i] & event_i[evsel_q[i]];
    perf_mon_counter #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_evt),
      .wr_i    (wr_evcnt && sel_ok && (sel_q == SEL_W'(i))),
      .wdata_i (wdata_i),
      .inc_i   (inc),
      .cnt_o   (ev_cnt[i]),
      .wrap_o  (ev_wrap[i])
    );
  end

  // ---------------- cycle counter
  logic cyc_run, cyc_tick, cyc_wrap;
  logic [CNT_W-1:0] cyc_cnt;

  assign cyc_run = ctrl_q.run & en_q[CYC_BIT] & ~(ctrl_q.prh & prohibit_i);

  perf_mon_prescale #(.LOG2(DIV_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_cyc),
    .run_i  (cyc_run),
    .div_i  (ctrl_q.div),
    .tick_o (cyc_tick)
  );

  perf_mon_counter #(.W(CNT_W)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_cyc),
    .wr_i    (wr_cyc),
    .wdata_i (wdata_i),
    .inc_i   (cyc_tick),
    .cnt_o   (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  // ---------------- overflow flags: a wrap wins over a same-cycle clear
  logic [CNT_W-1:0] wrap_v;
  always_comb begin
    wrap_v          = '0;
    wrap_v[CYC_BIT] = cyc_wrap;
    for (int i = 0; i < NUM_EVT; i++) wrap_v[i] = ev_wrap[i];
    ovf_d = ovf_q;
    if (wr_ovf) ovf_d = ovf_d & ~wdata_i;
    ovf_d = (ovf_d | wrap_v) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= ovf_d;
  end

  assign irq_o = |(ovf_q & ie_q);

  // ---------------- read mux
  logic [CNT_W-1:0] win_cnt;
  logic [EVS_W-1:0] win_sel;
  always_comb begin
    win_cnt = '0;
    win_sel = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (sel_q == SEL_W'(i)) begin
        win_cnt = ev_cnt[i];
        win_sel = evsel_q[i];
      end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:             rdata_o = {16'b0, 5'(NUM_EVT), 5'b0, ctrl_q.prh,
                                     ctrl_q.spare, ctrl_q.div, 2'b00, ctrl_q.run};
      A_EN_SET, A_EN_CLR: rdata_o = en_q;
      A_IE_SET, A_IE_CLR: rdata_o = ie_q;
      A_OVF:              rdata_o = ovf_q;
      A_SEL:              rdata_o = CNT_W'(sel_q);
      A_CYC:              rdata_o = cyc_cnt;
      A_EVCNT:            rdata_o = win_cnt;
      A_EVSEL:            rdata_o = CNT_W'(win_sel);
      default:            rdata_o = '0;
    endcase
  end

  // ---------------- assertions
  p_wrap_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_wrap |=> ovf_q[CYC_BIT]);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q[CYC_BIT] && !(wr_ovf && wdata_i[CYC_BIT])) |=> ovf_q[CYC_BIT]);
  p_en_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_clr |=> ((en_q & $past(wdata_i)) == '0));
  p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_set |=> ((en_q & $past(wdata_i) & IMPL) == ($past(wdata_i) & IMPL)));
  p_win_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evsel && !sel_ok) |=> $stable(evsel_q));
  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(ovf_q) > 0));
endmodule

// File: tb/perf_mon_test.sv
`timescale 1ns/100ps
module perf_mon_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [255:0] event_i = '0;
  logic         prohibit_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  perf_mon uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i), .prohibit_i(prohibit_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd_win(input int idx, output logic [31:0] d);
    wr(4'd6, 32'(idx));
    rd(4'd8, d);
  endtask

  // {write addr, write data, read addr, expected}
  localparam int NV = 18;
  localparam logic [71:0] VEC [NV] = '{
    {4'd0, 32'h0000_003F, 4'd0, 32'h0000_2039},  // R2
    {4'd0, 32'h0000_0000, 4'd0, 32'h0000_2000},  // R2
    {4'd1, 32'hFFFF_FFFF, 4'd1, 32'h8000_000F},  // R3
    {4'd2, 32'h0000_0005, 4'd2, 32'h8000_000A},  // R3
    {4'd2, 32'hFFFF_FFFF, 4'd1, 32'h0000_0000},  // R3
    {4'd3, 32'h8000_0001, 4'd4, 32'h8000_0001},  // R3
    {4'd4, 32'h8000_0000, 4'd3, 32'h0000_0001},  // R3
    {4'd4, 32'hFFFF_FFFF, 4'd3, 32'h0000_0000},  // R3
    {4'd6, 32'h0000_00FF, 4'd6, 32'h0000_001F},  // R10
    {4'd9, 32'h0000_0012, 4'd9, 32'h0000_0000},  // R10
    {4'd6, 32'h0000_0002, 4'd9, 32'h0000_0000},  // R10
    {4'd9, 32'h0000_01AB, 4'd9, 32'h0000_00AB},  // R11
    {4'd8, 32'h0000_1234, 4'd8, 32'h0000_1234},  // R11
    {4'd6, 32'h0000_0007, 4'd8, 32'h0000_0000},  // R10
    {4'd8, 32'h0000_5555, 4'd8, 32'h0000_0000},  // R10
    {4'd6, 32'h0000_0002, 4'd8, 32'h0000_1234},  // R10
    {4'd7, 32'h0000_ABCD, 4'd7, 32'h0000_ABCD},  // R11
    {4'd5, 32'hFFFF_FFFF, 4'd5, 32'h0000_0000}   // R8
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, a0, a1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 1; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset register", d, 32'h0);
    end
    rd(4'd0, d);
    check("R1 reset control", d, 32'h0000_2000);
    check("R1 reset irq", 32'(irq_o), 32'h0);

    // table walk: R2 R3 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd(VEC[i][35:32], d);
      check($sformatf("vector %0d", i), d, VEC[i][31:0]);
    end

    // R4 event counting
    wr(4'd0, 32'h6);
    wr(4'd6, 0); wr(4'd9, 5);
    wr(4'd6, 1); wr(4'd9, 9);
    wr(4'd6, 2); wr(4'd9, 5);
    wr(4'd1, 32'h3);
    event_i[5] = 1'b1;
    repeat (5) @(negedge clk_i);
    event_i[5] = 1'b0;
    rd_win(0, d);
    check("R4 global run off", d, 32'h0);
    wr(4'd0, 32'h1);
    event_i[5] = 1'b1; event_i[9] = 1'b1;
    repeat (3) @(negedge clk_i);
    event_i[9] = 1'b0;
    repeat (7) @(negedge clk_i);
    event_i[5] = 1'b0;
    rd_win(0, d); check("R4 counter0 event5", d, 32'd10);
    rd_win(1, d); check("R4 counter1 event9", d, 32'd3);
    rd_win(2, d); check("R4 counter2 not enabled", d, 32'd0);

    // R5 cycle counting
    wr(4'd1, 32'h8000_0000);
    rd(4'd7, a0); repeat (50) @(negedge clk_i); rd(4'd7, a1);
    check("R5 full rate", a1 - a0, 32'd50);
    wr(4'd0, 32'h9);
    rd(4'd7, a0); repeat (128) @(negedge clk_i); rd(4'd7, a1);
    check("R5 divide by 64", a1 - a0, 32'd2);

    // R6 prohibit
    prohibit_i = 1'b1;
    wr(4'd0, 32'h21);
    rd(4'd7, a0); repeat (20) @(negedge clk_i); rd(4'd7, a1);
    check("R6 paused", a1 - a0, 32'd0);
    wr(4'd0, 32'h01);
    rd(4'd7, a0); repeat (20) @(negedge clk_i); rd(4'd7, a1);
    check("R6 prohibit ignored", a1 - a0, 32'd20);
    prohibit_i = 1'b0;

    // R7 resets
    wr(4'd2, 32'h8000_0000);
    wr(4'd0, 32'h5);
    rd(4'd7, d); check("R7 cycle zeroed", d, 32'd0);
    rd_win(0, d); check("R7 events kept", d, 32'd10);
    wr(4'd7, 32'h77);
    wr(4'd0, 32'h3);
    rd_win(1, d); check("R7 events zeroed", d, 32'd0);
    rd(4'd7, d); check("R7 cycle kept", d, 32'h77);

    // R8 / R9 cycle wrap and interrupt
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFD);
    wr(4'd1, 32'h8000_0000);
    repeat (5) @(negedge clk_i);
    rd(4'd5, d); check("R8 cycle wrap flag", d, 32'h8000_0000);
    check("R9 irq masked", 32'(irq_o), 32'h0);
    wr(4'd3, 32'h8000_0000);
    check("R9 irq raised", 32'(irq_o), 32'h1);
    wr(4'd5, 32'h8000_0000);
    rd(4'd5, d); check("R8 flag cleared", d, 32'h0);
    check("R9 irq dropped", 32'(irq_o), 32'h0);
    wr(4'd2, 32'h8000_0000);

    // R8 wrap and clear on the same edge
    wr(4'd6, 0);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd1, 32'h1);
    wr_en_i = 1'b1; addr_i = 4'd5; wdata_i = 32'h1; event_i[5] = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; event_i[5] = 1'b0;
    rd(4'd5, d); check("R8 wrap beats clear", d, 32'h1);
    rd(4'd8, d); check("R8 counter wrapped", d, 32'h0);
    wr(4'd5, 32'h1);
    rd(4'd5, d); check("R8 later clear", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule